// File: doc/BRIEF.md
# Per-Instruction Lane Mask Generator

This block turns two small per-instruction fields, a mask mode and a lane index N, into an enable bitmap for the rows and a second, independent bitmap for the columns of a matrix operation. The accumulator array uses these bitmaps to decide which lanes an operation may write. Each dimension has its own mode and N, so every instruction can select a different row pattern and column pattern. No mask register file is involved.

The supported patterns are: every lane, even lanes only, odd lanes only, the N lowest lanes, the N highest lanes, and the single lane N. Memory transfers are never masked: when the memory flag is set, both bitmaps come out full. A mode code outside the defined set yields an empty bitmap and sets an illegal-mode flag for that dimension. The pattern logic is combinational. A small control register captures the result when an instruction is issued and holds it until the next issue.

Top module: `lane_mask_unit`

## Requirements
- R1: Mode code 0 (all) enables every lane of that dimension.
- R2: Mode code 1 (even) enables only lanes with an even index, counting lane 0 as even. Mode code 2 (odd) enables only lanes with an odd index.
- R3: Mode code 3 (first N) enables lanes 0 to N-1. N = 0 gives an empty mask. N at or above the lane count gives a full mask.
- R4: Mode code 4 (last N) enables the N highest-indexed lanes. N = 0 gives an empty mask. N at or above the lane count gives a full mask.
- R5: Mode code 5 (single) enables only lane N. An N at or above the lane count gives an empty mask.
- R6: Mode codes 6 and 7 give an all-zero mask for that dimension and set that dimension's illegal flag. Every other code clears the flag.
- R7: When `mem_op` is set on issue, both masks are all ones and both illegal flags are 0, whatever the modes and N values.
- R8: The row mask depends only on `row_mode`/`row_n`, and the column mask only on `col_mode`/`col_n`.
- R9: Outputs and flags are 0 during reset. They update on the clock edge at which `issue` is high, and hold their value while `issue` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Capture the masks for a new instruction |
| mem_op | input | 1 | Instruction is a load or store; masks are bypassed |
| row_mode | input | 3 | Row mask mode code |
| row_n | input | NW | Row index / count N |
| col_mode | input | 3 | Column mask mode code |
| col_n | input | NW | Column index / count N |
| row_en | output | ROWS | Row enable bitmap, bit i = row i |
| col_en | output | COLS | Column enable bitmap, bit i = column i |
| row_bad | output | 1 | Row mode code was illegal |
| col_bad | output | 1 | Column mode code was illegal |

## Verification
Two functions can apply in the same cycle: the memory bypass and the illegal-mode handling. The bench provokes this by issuing a memory operation that carries an illegal row code together with a zero-count column mode. It then checks that the bypass wins: both masks must be full and both flags clear. The bench also gives rows and columns different modes and edge-case N values in the same issue, so that any cross-coupling between the two generators shows up in the captured bitmaps.

// File: rtl/lane_mask_pkg.sv
package lane_mask_pkg;
   typedef enum logic [2:0] {
      LM_ALL    = 3'd0,
      LM_EVEN   = 3'd1,
      LM_ODD    = 3'd2,
      LM_FIRST  = 3'd3,
      LM_LAST   = 3'd4,
      LM_SINGLE = 3'd5
   } lm_mode_e;

   localparam int unsigned LM_MODE_W   = 3;
   localparam int unsigned LM_MODE_MAX = 5;
endpackage

// File: rtl/lane_mask_gen.sv
module lane_mask_gen
   import lane_mask_pkg::*;
#(
   parameter int unsigned LANES = 16,
   parameter int unsigned NW    = 6
) (
   input  logic [LM_MODE_W-1:0] mode,
   input  logic [NW-1:0]        n,
   output logic [LANES-1:0]     en,
   output logic                 bad
);
   localparam int unsigned N_EXT = 32;

   if (LANES < 1) begin : g_chk_lanes
      $error("lane_mask_gen: LANES must be at least 1");
   end
   if (NW < 1 || NW > 30) begin : g_chk_nw
      $error("lane_mask_gen: NW must be in 1..30");
   end

   logic [N_EXT-1:0] n_ext;
   assign n_ext = N_EXT'(n);
   assign bad   = (mode > LM_MODE_W'(LM_MODE_MAX));

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic lane_on;
      always_comb begin
         case (mode)
            LM_ALL:    lane_on = 1'b1;
            LM_EVEN:   lane_on = ((i % 2) == 0);
            LM_ODD:    lane_on = ((i % 2) == 1);
            LM_FIRST:  lane_on = (n_ext > N_EXT'(i));
            LM_LAST:   lane_on = ((n_ext + N_EXT'(i)) >= N_EXT'(LANES));
            LM_SINGLE: lane_on = (n_ext == N_EXT'(i));
            default:   lane_on = 1'b0;
         endcase
      end
      assign en[i] = lane_on;
   end

   // R5: at most one lane in single mode
   always_comb begin
      if (mode == LM_SINGLE)
         a_r5_single_onehot: assert ($onehot0(en));
   end

   // R6: illegal code gives no lanes
   always_comb begin
      if (bad)
         a_r6_illegal_empty: assert (en == '0);
   end

   // R3: first-N mask population matches N when N fits
   always_comb begin
      if (mode == LM_FIRST && n_ext <= N_EXT'(LANES))
         a_r3_first_count: assert (N_EXT'($countones(en)) == n_ext);
   end
endmodule

// File: rtl/lane_mask_unit.sv
module lane_mask_unit
   import lane_mask_pkg::*;
#(
   parameter int unsigned ROWS = 16,
   parameter int unsigned COLS = 16,
   parameter int unsigned NW   = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 issue,
   input  logic                 mem_op,
   input  logic [LM_MODE_W-1:0] row_mode,
   input  logic [NW-1:0]        row_n,
   input  logic [LM_MODE_W-1:0] col_mode,
   input  logic [NW-1:0]        col_n,
   output logic [ROWS-1:0]      row_en,
   output logic [COLS-1:0]      col_en,
   output logic                 row_bad,
   output logic                 col_bad
);
   if ((2 ** NW) <= ROWS || (2 ** NW) <= COLS) begin : g_chk_nw
      $error("lane_mask_unit: NW too narrow to name every lane");
   end

   logic [ROWS-1:0] row_gen;
   logic [COLS-1:0] col_gen;
   logic            row_gen_bad, col_gen_bad;

   lane_mask_gen #(.LANES(ROWS), .NW(NW)) u_row_gen (
      .mode(row_mode), .n(row_n), .en(row_gen), .bad(row_gen_bad)
   );

   lane_mask_gen #(.LANES(COLS), .NW(NW)) u_col_gen (
      .mode(col_mode), .n(col_n), .en(col_gen), .bad(col_gen_bad)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_en  <= '0;
         col_en  <= '0;
         row_bad <= 1'b0;
         col_bad <= 1'b0;
      end else if (issue) begin
         row_en  <= mem_op ? '1 : row_gen;
         col_en  <= mem_op ? '1 : col_gen;
         row_bad <= mem_op ? 1'b0 : row_gen_bad;
         col_bad <= mem_op ? 1'b0 : col_gen_bad;
      end
   end

   a_r7_mem_full: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && mem_op) |=> (&row_en && &col_en && !row_bad && !col_bad));

   a_r6_illegal_rows: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && !mem_op && row_mode > 3'd5) |=> (row_en == '0 && row_bad));

   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !issue |=> ($stable(row_en) && $stable(col_en) &&
                  $stable(row_bad) && $stable(col_bad)));

   a_r1_all_cols: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && col_mode == 3'd0) |=> &col_en);
endmodule

// File: tb/lane_mask_unit_tb.sv
module lane_mask_unit_tb;
   localparam int ROWS = 16;
   localparam int COLS = 8;
   localparam int NW   = 5;
   localparam int NV   = 11;

   // {mem, rmode, rn, cmode, cn, exp_row, exp_col, exp_rbad, exp_cbad}
   localparam int VW = 1 + 3 + NW + 3 + NW + ROWS + COLS + 2;
   localparam logic [VW-1:0] VEC [NV] = '{
      {1'b0, 3'd0, 5'd0,  3'd0, 5'd0,  16'hFFFF, 8'hFF, 2'b00}, // R1
      {1'b0, 3'd1, 5'd0,  3'd2, 5'd0,  16'h5555, 8'hAA, 2'b00}, // R2 R8
      {1'b0, 3'd3, 5'd3,  3'd4, 5'd2,  16'h0007, 8'hC0, 2'b00}, // R3 R4
      {1'b0, 3'd3, 5'd0,  3'd4, 5'd0,  16'h0000, 8'h00, 2'b00}, // R3 R4 zero
      {1'b0, 3'd3, 5'd16, 3'd4, 5'd9,  16'hFFFF, 8'hFF, 2'b00}, // R3 R4 over
      {1'b0, 3'd5, 5'd15, 3'd5, 5'd8,  16'h8000, 8'h00, 2'b00}, // R5
      {1'b0, 3'd5, 5'd0,  3'd5, 5'd7,  16'h0001, 8'h80, 2'b00}, // R5
      {1'b0, 3'd6, 5'd3,  3'd7, 5'd1,  16'h0000, 8'h00, 2'b11}, // R6
      {1'b1, 3'd6, 5'd3,  3'd3, 5'd0,  16'hFFFF, 8'hFF, 2'b00}, // R7
      {1'b0, 3'd4, 5'd5,  3'd3, 5'd31, 16'hF800, 8'hFF, 2'b00}, // R4 R3
      {1'b0, 3'd3, 5'd15, 3'd1, 5'd9,  16'h7FFF, 8'h55, 2'b00}  // R3 R2
   };

   logic clk = 0, rst_n = 0, issue = 0, mem_op = 0;
   logic [2:0] row_mode = 0, col_mode = 0;
   logic [NW-1:0] row_n = 0, col_n = 0;
   logic [ROWS-1:0] row_en;
   logic [COLS-1:0] col_en;
   logic row_bad, col_bad;
   int tests = 0, fails = 0;

   always #2 clk = ~clk;

   lane_mask_unit #(.ROWS(ROWS), .COLS(COLS), .NW(NW)) u_dut (
      .clk(clk), .rst_n(rst_n), .issue(issue), .mem_op(mem_op),
      .row_mode(row_mode), .row_n(row_n), .col_mode(col_mode), .col_n(col_n),
      .row_en(row_en), .col_en(col_en), .row_bad(row_bad), .col_bad(col_bad)
   );

   task automatic check(input string req, input logic [ROWS-1:0] er,
                        input logic [COLS-1:0] ec, input logic [1:0] eb);
      tests++;
      if (row_en !== er || col_en !== ec || {row_bad, col_bad} !== eb) begin
         fails++;
         $display("FAIL %s: got row=%h col=%h bad=%b exp row=%h col=%h bad=%b",
                  req, row_en, col_en, {row_bad, col_bad}, er, ec, eb);
      end
   endtask

   initial begin
      #400000;
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R9 reset", '0, '0, 2'b00);
      rst_n = 1;
      @(negedge clk);
      check("R9 idle after reset", '0, '0, 2'b00);

      for (int v = 0; v < NV; v++) begin
         logic [VW-1:0] e;
         e = VEC[v];
         {mem_op, row_mode, row_n, col_mode, col_n} = e[VW-1 -: 1+3+NW+3+NW];
         issue = 1;
         @(negedge clk);
         issue = 0;
         check($sformatf("R1-style vector %0d (R2 R3 R4 R5 R6 R7 R8)", v),
               e[ROWS+COLS+1 -: ROWS], e[COLS+1 -: COLS], e[1:0]);
      end

      // R9: inputs change without issue, outputs hold
      mem_op = 0; row_mode = 3'd0; col_mode = 3'd6;
      @(negedge clk);
      check("R9 hold", 16'h7FFF, 8'h55, 2'b00);

      // R8: change only columns, rows unaffected
      row_mode = 3'd2; row_n = 0; col_mode = 3'd5; col_n = 5'd3;
      issue = 1; @(negedge clk); issue = 0;
      check("R8 odd rows single col", 16'hAAAA, 8'h08, 2'b00);

      // R6: illegal rows only, column flag stays clear
      row_mode = 3'd7; col_mode = 3'd0;
      issue = 1; @(negedge clk); issue = 0;
      check("R6 row illegal only", 16'h0000, 8'hFF, 2'b10);

      // R7 then R9 reset clears
      mem_op = 1; row_mode = 3'd5; row_n = 5'd31;
      issue = 1; @(negedge clk); issue = 0; mem_op = 0;
      check("R7 mem bypass", 16'hFFFF, 8'hFF, 2'b00);
      rst_n = 0; @(negedge clk);
      check("R9 reset clears", '0, '0, 2'b00);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule